// File: doc/BRIEF.md
# Cascaded Programmable Clock Divider

This block divides its clock by a programmable integer ratio. The counter is a chain of 8-bit counting slices, four of them by default, so the chain is 32 bits wide. It counts upward from a preset toward all ones. The preset is 2^W minus the chain ratio. When every slice holds all ones at the same time, the block emits a one-cycle tick and the whole chain reloads the preset. The tick therefore repeats once every ratio clocks.

A slice advances only while every lower slice sits at its own terminal count. The lowest slice advances on every clock. The enable is a ripple of the slice terminal counts, not one wide adder and comparator. A toggle flop driven by the chain tick gives a square output. In even mode the chain is run at half the requested ratio, so the square wave has a period of exactly the requested ratio and a 50% duty cycle.

A new ratio is offered by pulsing `start` with `ratio` and `even_mode` valid. The block checks the request. If it is accepted, it is held pending and installed at the next whole-chain reload. A request out of range is dropped.

Top module: `wide_divider`

## Requirements
- R1: While `rst` is high the chain loads the preset for the default ratio of 256 and `sq_out` is 0. After `rst` falls, the first `div_tick` is seen 255 clocks later.
- R2: In normal mode an accepted ratio N sets the preset to 2^W − N, so that `div_tick` rises every N clocks. The ratio 113 gives the preset 0x8F in the lowest slice.
- R3: `div_tick` is high for exactly one clock per period, including at the smallest ratio 2.
- R4: A slice increments only when all lower slices are at all ones, and the lowest slice increments on every clock. The chain as a whole advances by one per clock, and ratios that carry across slice boundaries (773, 65541) give exact periods.
- R5: The chain reloads only when every slice is at all ones at the same time. A single slice reaching all ones does not trigger a reload.
- R6: In normal mode the accepted ratios run from 2 up to 2^W inclusive. Ratio 2 gives a tick on every second clock and ratio 256 gives a tick every 256 clocks.
- R7: A request is ignored and the previous ratio kept in any of these cases: a ratio of 0 or 1, a ratio above 2^W, or, in even mode, an odd ratio or a ratio below 4.
- R8: An accepted ratio takes effect only at the next whole-chain reload. The period in progress completes at the old length.
- R9: In even mode (`even_mode`=1) with an even ratio N, the chain runs at N/2. `sq_out` is then high for N/2 clocks and low for N/2 clocks.
- R10: `sq_out` inverts on the clock edge that follows each `div_tick` and holds its value otherwise. In normal mode its period is therefore 2N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ratio | input | W+1 | Requested divide ratio, sampled when `start` is high |
| even_mode | input | 1 | 1 = square-wave mode, chain runs at ratio/2 |
| start | input | 1 | One-cycle request to install `ratio` and `even_mode` |
| div_tick | output | 1 | One-cycle pulse when the whole chain is at all ones |
| sq_out | output | 1 | Toggle output, inverted after each tick |

## Verification
The bench times the tick-to-tick interval at ratios 2, 113, 256, 773 and 65541. The last two exercise the carries between slices. A chain that reloaded on a single slice's terminal count, or that enabled a slice from only its nearest neighbour, would give a short period at those ratios. Each illegal request is followed by a measured period, so a design that let a bad request through would show a changed interval. A request issued mid-period must leave that period at its old length, which catches a design that reloads as soon as a request arrives. Even mode is checked by the high and low widths of the square wave, which exposes a design that ran the chain at N or at 2N.

// File: rtl/wide_divider_pkg.sv
package wide_divider_pkg;

  // Ratio the counter chain itself must realise: half the request in even mode.
  function automatic logic [64:0] chain_ratio(input logic [64:0] req, input logic even);
    return even ? (req >> 1) : req;
  endfunction

  // Legality of a request for a chain of width w.
  function automatic logic ratio_ok(input logic [64:0] req, input logic even, input int w);
    logic [64:0] lim;
    logic ok;
    lim = 65'(1) << w;
    ok  = (req >= 65'd2) && (req <= lim);
    if (even) ok = ok && !req[0] && (req >= 65'd4);
    return ok;
  endfunction

  // Start value so that the chain reaches all ones after n-1 increments.
  function automatic logic [64:0] preset_of(input logic [64:0] n, input int w);
    return (65'(1) << w) - n;
  endfunction

endpackage

// File: rtl/count_slice.sv
module count_slice #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          load,
  input  logic [SW-1:0] preset,
  output logic [SW-1:0] q,
  output logic          at_top
);
  always_ff @(posedge clk) begin
    if (rst || load) q <= preset;
    else if (en)     q <= q + 1'b1;
  end

  assign at_top = &q;
endmodule

// File: rtl/ratio_cfg.sv
module ratio_cfg
  import wide_divider_pkg::*;
#(
  parameter int W             = 32,
  parameter int DEFAULT_RATIO = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W:0]   ratio,
  input  logic         even_mode,
  output logic         accept,
  output logic [W-1:0] pend_preset,
  output logic [W-1:0] rst_preset
);
  localparam logic [64:0] DEF_PRESET = preset_of(65'(DEFAULT_RATIO), W);

  logic [64:0] req;
  assign req        = 65'(ratio);
  assign accept     = start && ratio_ok(req, even_mode, W);
  assign rst_preset = DEF_PRESET[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)         pend_preset <= DEF_PRESET[W-1:0];
    else if (accept) pend_preset <= W'(preset_of(chain_ratio(req, even_mode), W));
  end
endmodule

// File: rtl/wide_divider.sv
module wide_divider #(
  parameter int SLICE_W       = 8,
  parameter int NUM_SLICES    = 4,
  parameter int DEFAULT_RATIO = 256,
  localparam int W            = SLICE_W * NUM_SLICES
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [W:0] ratio,
  input  logic       even_mode,
  input  logic       start,
  output logic       div_tick,
  output logic       sq_out
);
  logic [W-1:0]          pend_preset;
  logic [W-1:0]          rst_preset;
  logic [W-1:0]          preset_w;
  logic [W-1:0]          count_w;
  logic [NUM_SLICES-1:0] slice_top;
  logic [NUM_SLICES-1:0] slice_en;
  logic                  accept_w;
  logic                  chain_reload;

  ratio_cfg #(.W(W), .DEFAULT_RATIO(DEFAULT_RATIO)) u_cfg (
    .clk(clk), .rst(rst), .start(start), .ratio(ratio), .even_mode(even_mode),
    .accept(accept_w), .pend_preset(pend_preset), .rst_preset(rst_preset)
  );

  assign preset_w     = pend_preset;
  assign chain_reload = &slice_top;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    if (i == 0) begin : g_low
      assign slice_en[i] = 1'b1;
    end else begin : g_up
      assign slice_en[i] = slice_en[i-1] & slice_top[i-1];
    end
    count_slice #(.SW(SLICE_W)) u_slice (
      .clk(clk), .rst(rst), .en(slice_en[i]), .load(chain_reload),
      .preset(rst ? rst_preset[i*SLICE_W +: SLICE_W] : preset_w[i*SLICE_W +: SLICE_W]),
      .q(count_w[i*SLICE_W +: SLICE_W]), .at_top(slice_top[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)               sq_out <= 1'b0;
    else if (chain_reload) sq_out <= ~sq_out;
  end

  assign div_tick = chain_reload;
endmodule

// File: rtl/wide_divider_chk.sv
module wide_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         sq,
  input logic [W-1:0] count,
  input logic [W-1:0] preset,
  input logic         accept
);
  // R5: reload installs the pending preset across all slices
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    tick |=> count == $past(preset));

  // R4: without a reload the slice chain behaves as one incrementer
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> count == W'($past(count) + 1'b1));

  // R7: the pending preset moves only on an accepted request
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(preset));

  // R10: square output inverts after a tick
  p_sq_toggle_r10: assert property (@(posedge clk) disable iff (rst)
    tick |=> sq != $past(sq));

  // R10: square output holds between ticks
  p_sq_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sq));

  // R3: tick never lasts two cycles
  p_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

bind wide_divider wide_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(div_tick), .sq(sq_out),
  .count(count_w), .preset(preset_w), .accept(accept_w)
);

// File: tb/wide_divider_tb.sv
module wide_divider_tb;
  localparam int W = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [W:0] ratio = '0;
  logic       even_mode = 1'b0;
  logic       start = 1'b0;
  logic       div_tick;
  logic       sq_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  wide_divider u_dut (
    .clk(clk), .rst(rst), .ratio(ratio), .even_mode(even_mode),
    .start(start), .div_tick(div_tick), .sq_out(sq_out)
  );

  task automatic check(input longint act, input longint exp, input string req, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_tick();
    while (!div_tick) @(negedge clk);
  endtask

  task automatic interval(output longint n);
    n = 0;
    do begin @(negedge clk); n++; end while (!div_tick);
  endtask

  task automatic request(input longint r, input logic ev);
    @(negedge clk);
    while (div_tick) @(negedge clk);
    ratio = (W+1)'(r); even_mode = ev; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    longint n;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(sq_out, 0, "R1", "sq in reset");
    rst = 1'b0;
    interval(n);
    check(n, 255, "R1", "first tick after reset");
    interval(n);
    check(n, 256, "R6", "default ratio 256");
  endtask

  task automatic t_ratio(input longint r, input string req);
    longint n;
    logic   s0;
    request(r, 1'b0);
    wait_tick();
    s0 = sq_out;
    interval(n);
    check(n, r, req, "tick period");
    check(sq_out, !s0, "R10", "sq inverted after tick");
    @(negedge clk);
    check(div_tick, (r == 1) ? 1 : 0, "R3", "tick one cycle");
  endtask

  task automatic t_min();
    longint n;
    request(2, 1'b0);
    wait_tick();
    interval(n);
    check(n, 2, "R6", "ratio 2 period a");
    interval(n);
    check(n, 2, "R6", "ratio 2 period b");
    @(negedge clk);
    check(div_tick, 0, "R3", "ratio 2 tick low between");
  endtask

  task automatic t_reject();
    longint n;
    longint bad [5] = '{0, 1, 64'h1_0000_0001, 7, 2};
    logic   bev [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    request(113, 1'b0);
    wait_tick();
    for (int k = 0; k < 5; k++) begin
      request(bad[k], bev[k]);
      wait_tick();
      interval(n);
      check(n, 113, "R7", $sformatf("rejected request %0d", k));
    end
  endtask

  task automatic t_no_trunc();
    longint n;
    request(113, 1'b0);
    wait_tick();
    interval(n);
    repeat (10) @(negedge clk);
    ratio = (W+1)'(50); even_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 11;
    while (!div_tick) begin @(negedge clk); n++; end
    check(n, 113, "R8", "period in progress kept");
    interval(n);
    check(n, 50, "R8", "new ratio after reload");
  endtask

  task automatic t_even(input longint r);
    longint hi;
    longint lo;
    request(r, 1'b1);
    wait_tick();
    @(negedge clk);
    while (sq_out) @(negedge clk);
    while (!sq_out) @(negedge clk);
    hi = 0;
    while (sq_out) begin hi++; @(negedge clk); end
    lo = 0;
    while (!sq_out) begin lo++; @(negedge clk); end
    check(hi, r / 2, "R9", "square high width");
    check(lo, r / 2, "R9", "square low width");
  endtask

  initial begin
    t_reset();
    t_ratio(113, "R2");
    t_min();
    t_ratio(256, "R6");
    t_ratio(773, "R4");
    t_ratio(773, "R5");
    t_reject();
    t_no_trunc();
    t_even(10);
    t_even(114);
    t_ratio(65541, "R4");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule